// File: doc/BRIEF.md
# Level-Masked Interrupt Acceptor

This block sits beside a processor core and decides when a maskable interrupt is taken. Each request line carries a fixed priority level, set by a parameter, from 1 (most urgent) to 16. A 3-bit mask code from the status register acts as a threshold. Code 0 admits every level. Each step of the code above 0 lowers the highest admitted level by two. Code 7 admits nothing.

When at least one pending request passes the mask, the block takes a snapshot of the program counter, the flag byte and the stack pointer. It then runs a fixed entry sequence. It writes three bytes to a byte-wide stack through a memory write port, each write going to a pre-decremented stack address. After the writes it presents, in a single cycle, the new stack pointer, the vector address for the chosen source and a one-hot acknowledge. While the sequence runs, the block does not look at its inputs.

Top module: `irq_accept`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `mem_we`, `ack_vec`, `vec_load` and `sp_we` are all 0.
- R2: A level field value v means level v+1. A request of level L is admitted under mask code m when m is 0, or when m is between 1 and 6 and L is at most 14-2m.
- R3: Mask code 7 admits no request, and no entry sequence starts.
- R4: Among the admitted pending requests, the lowest level number wins. On equal levels, the lower request index wins.
- R5: The acceptance clock edge captures `pc`, `flags` and `sp`. In the three cycles after it, `mem_we` is 1 and the port writes `pc[7:0]` to sp-1, then `pc[15:8]` to sp-2, then `flags` to sp-3. Addresses wrap modulo 2^16.
- R6: The fourth cycle after acceptance is a single cycle in which all of the following hold. `ack_vec` has only the winner's bit set. `vec_load` is 1 with `vec_addr` = VEC_BASE + 2*index. `sp_we` is 1 with `sp_wdata` = sp-3.
- R7: During cycles 1 to 4 of a sequence, changes on `irq_req`, `mask_code`, `pc`, `flags` and `sp` have no effect on the sequence.
- R8: If an admitted request is still pending after the acknowledge, the next sequence writes its first byte exactly two cycles after the acknowledge cycle.
- R9: `busy` is 1 in exactly the four cycles after an acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | N | Pending request per source |
| mask_code | input | 3 | Level threshold code |
| flags | input | 8 | Flag byte to save |
| pc | input | 16 | Program counter to save |
| sp | input | 16 | Current stack pointer |
| busy | output | 1 | Entry sequence in progress |
| mem_we | output | 1 | Stack byte write strobe |
| mem_addr | output | 16 | Stack write address |
| mem_wdata | output | 8 | Stack write byte |
| ack_vec | output | N | One-hot acknowledge to the source |
| vec_load | output | 1 | Load vector into program counter |
| vec_addr | output | 16 | Vector address |
| sp_we | output | 1 | Stack pointer update strobe |
| sp_wdata | output | 16 | New stack pointer |

## Verification
The bench drives each stimulus half a cycle before the acceptance edge. It then samples at the falling edges that follow. The three stack writes are expected one, two and three cycles after acceptance, and the acknowledge, vector load and stack pointer update four cycles after it. A refused request is checked one and two cycles later for the absence of `busy` and writes. The bench changes every input at the first write cycle, so R7 is visible in the later cycles of the same sequence. For R8 the request is held through the acknowledge, and the next write is expected two cycles after it.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

    localparam int LVL_W  = 4;
    localparam int ADDR_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PCL,
        ST_PCH,
        ST_FLG,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [7:0]        flags;
        logic [ADDR_W-1:0] sp;
    } snapshot_t;

    // v is level-1; admitted when level <= 14-2m, i.e. v <= 13-2m
    function automatic logic level_admitted(input logic [LVL_W-1:0] v,
                                            input logic [2:0] m);
        logic [4:0] lim;
        if (m == 3'd0) return 1'b1;
        if (m == 3'd7) return 1'b0;
        lim = 5'd13 - {1'b0, m, 1'b0};
        return {1'b0, v} <= lim;
    endfunction

endpackage

// File: rtl/irq_pick.sv
module irq_pick
    import irq_accept_pkg::*;
#(
    parameter int N     = 5,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1,
    parameter logic [N*LVL_W-1:0] LVL_CODES = '0
) (
    input  logic [N-1:0]     req,
    input  logic [2:0]       mask_code,
    output logic             found,
    output logic [IDX_W-1:0] win_idx
);
    logic [N-1:0]       admitted;
    logic [LVL_W-1:0]   lvl [N];

    for (genvar g = 0; g < N; g++) begin : g_src
        assign lvl[g]      = LVL_CODES[g*LVL_W +: LVL_W];
        assign admitted[g] = req[g] && level_admitted(lvl[g], mask_code);
    end

    logic [LVL_W-1:0] best_lvl;

    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        best_lvl = '1;
        for (int i = 0; i < N; i++) begin
            if (admitted[i] && (!found || lvl[i] < best_lvl)) begin
                found    = 1'b1;
                best_lvl = lvl[i];
                win_idx  = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_accept_pkg::*;
#(
    parameter int N     = 5,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1,
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IDX_W-1:0]  start_idx,
    input  snapshot_t         snap_in,
    output logic              idle,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic [N-1:0]      ack_vec,
    output logic              vec_load,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              sp_we,
    output logic [ADDR_W-1:0] sp_wdata
);
    seq_state_e        state;
    snapshot_t         snap;
    logic [IDX_W-1:0]  idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            snap  <= '0;
            idx   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    state <= ST_PCL;
                    snap  <= snap_in;
                    idx   <= start_idx;
                end
                ST_PCL:  state <= ST_PCH;
                ST_PCH:  state <= ST_FLG;
                ST_FLG:  state <= ST_DONE;
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    logic [ADDR_W-1:0] vec_off;
    always_comb begin
        vec_off            = '0;
        vec_off[IDX_W:1]   = idx;
    end

    always_comb begin
        idle      = (state == ST_IDLE);
        busy      = !idle;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        ack_vec   = '0;
        vec_load  = 1'b0;
        vec_addr  = '0;
        sp_we     = 1'b0;
        sp_wdata  = '0;
        case (state)
            ST_PCL: begin
                mem_we    = 1'b1;
                mem_addr  = snap.sp - 16'd1;
                mem_wdata = snap.pc[7:0];
            end
            ST_PCH: begin
                mem_we    = 1'b1;
                mem_addr  = snap.sp - 16'd2;
                mem_wdata = snap.pc[15:8];
            end
            ST_FLG: begin
                mem_we    = 1'b1;
                mem_addr  = snap.sp - 16'd3;
                mem_wdata = snap.flags;
            end
            ST_DONE: begin
                ack_vec[idx] = 1'b1;
                vec_load     = 1'b1;
                vec_addr     = VEC_BASE + vec_off;
                sp_we        = 1'b1;
                sp_wdata     = snap.sp - 16'd3;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_accept.sv
module irq_accept
    import irq_accept_pkg::*;
#(
    parameter int N = 5,
    parameter logic [N*LVL_W-1:0] LVL_CODES = {4'd0, 4'd15, 4'd11, 4'd0, 4'd2},
    parameter logic [15:0] VEC_BASE = 16'h0100
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] irq_req,
    input  logic [2:0]   mask_code,
    input  logic [7:0]   flags,
    input  logic [15:0]  pc,
    input  logic [15:0]  sp,
    output logic         busy,
    output logic         mem_we,
    output logic [15:0]  mem_addr,
    output logic [7:0]   mem_wdata,
    output logic [N-1:0] ack_vec,
    output logic         vec_load,
    output logic [15:0]  vec_addr,
    output logic         sp_we,
    output logic [15:0]  sp_wdata
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic             found;
    logic [IDX_W-1:0] win_idx;
    logic             idle;
    snapshot_t        snap_in;

    assign snap_in = '{pc: pc, flags: flags, sp: sp};

    irq_pick #(.N(N), .IDX_W(IDX_W), .LVL_CODES(LVL_CODES)) u_pick (
        .req       (irq_req),
        .mask_code (mask_code),
        .found     (found),
        .win_idx   (win_idx)
    );

    irq_entry_seq #(.N(N), .IDX_W(IDX_W), .VEC_BASE(VEC_BASE)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (found),
        .start_idx (win_idx),
        .snap_in   (snap_in),
        .idle      (idle),
        .busy      (busy),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .ack_vec   (ack_vec),
        .vec_load  (vec_load),
        .vec_addr  (vec_addr),
        .sp_we     (sp_we),
        .sp_wdata  (sp_wdata)
    );

endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
    parameter int N = 5
) (
    input logic         clk,
    input logic         rst,
    input logic [2:0]   mask_code,
    input logic         busy,
    input logic         mem_we,
    input logic [15:0]  mem_addr,
    input logic [N-1:0] ack_vec,
    input logic         vec_load,
    input logic         sp_we,
    input logic [15:0]  sp_wdata
);
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        rst |=> (!busy && !mem_we && ack_vec == '0 && !vec_load && !sp_we));

    assert_mask7_blocks_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy && mask_code == 3'd7) |=> !busy);

    assert_addr_predec_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 16'd1));

    assert_write_needs_busy_R9: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    assert_ack_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_vec));

    assert_ack_with_vec_R6: assert property (@(posedge clk) disable iff (rst)
        (ack_vec != '0) |-> (vec_load && sp_we && $past(mem_we)));

    assert_ack_single_R6: assert property (@(posedge clk) disable iff (rst)
        vec_load |=> !vec_load);

    assert_sp_matches_last_write_R5: assert property (@(posedge clk) disable iff (rst)
        (sp_we && $past(mem_we)) |-> (sp_wdata == $past(mem_addr)));

endmodule

bind irq_accept irq_accept_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mask_code (mask_code),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .ack_vec   (ack_vec),
    .vec_load  (vec_load),
    .sp_we     (sp_we),
    .sp_wdata  (sp_wdata)
);

// File: tb/tb_irq_accept.sv
module tb_irq_accept;
    localparam int N = 5;
    localparam logic [15:0] VB = 16'h0100;
    // levels (1..16) per source, independent of the RTL parameter encoding
    localparam int LV [N] = '{3, 1, 12, 16, 1};

    logic clk = 0, rst = 1;
    logic [N-1:0] irq_req = '0;
    logic [2:0]  mask_code = '0;
    logic [7:0]  flags = '0;
    logic [15:0] pc = '0, sp = '0;
    logic busy, mem_we, vec_load, sp_we;
    logic [15:0] mem_addr, vec_addr, sp_wdata;
    logic [7:0] mem_wdata;
    logic [N-1:0] ack_vec;

    int total = 0, bad = 0;

    always #2 clk = ~clk;

    irq_accept #(.N(N), .LVL_CODES({4'd0, 4'd15, 4'd11, 4'd0, 4'd2}), .VEC_BASE(VB)) dut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .mask_code(mask_code),
        .flags(flags), .pc(pc), .sp(sp), .busy(busy), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .ack_vec(ack_vec),
        .vec_load(vec_load), .vec_addr(vec_addr), .sp_we(sp_we), .sp_wdata(sp_wdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int pick(input logic [N-1:0] r, input int m);
        int lim, best, bl;
        lim = (m == 0) ? 16 : (m == 7) ? 0 : 14 - 2 * m;
        best = -1; bl = 99;
        for (int i = 0; i < N; i++)
            if (r[i] && LV[i] <= lim && LV[i] < bl) begin best = i; bl = LV[i]; end
        return best;
    endfunction

    // inputs set at negedge; acceptance at next posedge; result checks at negedges
    task automatic run_case(input logic [N-1:0] r, input int m, input int k, input bit hold);
        int w;
        logic [15:0] epc, esp;
        logic [7:0] efl;
        epc = 16'h1234 ^ 16'(k * 16'h0307);
        esp = 16'(k * 5);
        efl = 8'(k * 3 + 1);
        irq_req = r; mask_code = 3'(m); pc = epc; sp = esp; flags = efl;
        w = pick(r, m);
        @(negedge clk);
        if (w < 0) begin
            chk(m == 7 ? "R3 no start" : "R2 refused", {30'd0, busy, mem_we}, 32'd0);
            irq_req = '0;
            @(negedge clk);
            chk("R2 still idle", {31'd0, busy}, 32'd0);
            return;
        end
        chk("R9 busy c1", {31'd0, busy}, 32'd1);
        chk("R5 write c1", {15'd0, mem_we, mem_addr}, {15'd0, 1'b1, esp - 16'd1});
        chk("R5 pcl", {24'd0, mem_wdata}, {24'd0, epc[7:0]});
        if (!hold) begin
            // R7: disturb all inputs mid-sequence
            irq_req = '1; mask_code = 3'd0; pc = ~epc; sp = ~esp; flags = ~efl;
        end
        @(negedge clk);
        chk("R5 write c2", {15'd0, mem_we, mem_addr}, {15'd0, 1'b1, esp - 16'd2});
        chk("R5 pch", {24'd0, mem_wdata}, {24'd0, epc[15:8]});
        @(negedge clk);
        chk("R5 write c3", {15'd0, mem_we, mem_addr}, {15'd0, 1'b1, esp - 16'd3});
        chk("R7 flags kept", {24'd0, mem_wdata}, {24'd0, efl});
        @(negedge clk);
        chk("R4 R6 ack", {27'd0, ack_vec}, 32'd1 << w);
        chk("R6 vec", {15'd0, vec_load, vec_addr}, {15'd0, 1'b1, VB + 16'(2 * w)});
        chk("R6 sp", {15'd0, sp_we, sp_wdata}, {15'd0, 1'b1, esp - 16'd3});
        chk("R9 busy c4", {31'd0, busy, mem_we}, 32'd2);
        if (hold) begin
            @(negedge clk);
            chk("R8 gap idle", {30'd0, busy, vec_load}, 32'd0);
            @(negedge clk);
            chk("R8 next write", {15'd0, mem_we, mem_addr}, {15'd0, 1'b1, esp - 16'd1});
            irq_req = '0;
            repeat (4) @(negedge clk);
        end else begin
            irq_req = '0;
            @(negedge clk);
            chk("R9 busy drop", {31'd0, busy}, 32'd0);
        end
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset outs", {27'd0, busy, mem_we, vec_load, sp_we, |ack_vec}, 32'd0);
        rst = 0;
        @(negedge clk);
        chk("R1 after reset", {28'd0, busy, mem_we, vec_load, sp_we}, 32'd0);
        for (int m = 0; m < 8; m++)
            for (int p = 0; p < (1 << N); p++)
                run_case(N'(p), m, m * 32 + p, 1'b0);
        run_case(5'b00001, 0, 7, 1'b1);
        run_case(5'b10010, 6, 9, 1'b1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule